// File: doc/BRIEF.md
# Global-History Correlated Branch Predictor

This block predicts the direction of conditional branches. It combines the address of the branch with the outcomes of the most recent branches, wherever those branches sit in the program. One shift register keeps those recent outcomes for the whole core. A table of 2-bit saturating counters is split into rows, selected by low program-counter bits, and columns, selected by the shift register. The counter found at that crossing gives the prediction.

The front end puts a branch PC on the lookup port. In the same cycle it receives a taken/not-taken guess and the table index that produced it. It carries that index down the pipeline with the branch. When the branch resolves, the back end returns the saved index and the real direction on the update port. The block then steps the selected counter toward that direction and shifts the direction into the history. Lookups are combinational and have no side effect. Updates take effect at the next clock edge.

Top module: `corr_branch_predictor`

## Requirements
- R1: On synchronous active-high reset the history becomes all zeros and every counter becomes 01, so each lookup after reset predicts not taken and reports a history column of zero.
- R2: On each clock edge with `upd_valid` high, the history shifts one place toward its most significant bit and `upd_taken` enters at bit 0. With `upd_valid` low the history holds, whatever `upd_taken` is.
- R3: `pred_idx` is the concatenation {row, column}. The row, in the upper `ROW_W` bits, is `pred_pc[ALIGN_BITS +: ROW_W]`. The column, in the lower `HIST_W` bits, is the current history.
- R4: Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. The lookup predicts taken exactly when bit 1 of the selected counter is 1.
- R5: An update with `upd_taken` = 1 increments the counter at `upd_idx`. A counter already at 11 stays at 11.
- R6: An update with `upd_taken` = 0 decrements the counter at `upd_idx`. A counter already at 00 stays at 00.
- R7: An update writes only the counter addressed by the `upd_idx` it carries, even when the current history points elsewhere. All other counters keep their values.
- R8: When a lookup and an update address the same counter in the same cycle, the lookup returns the value from before the update, and the column it reports is the history from before the shift.
- R9: PC bits below `ALIGN_BITS` and bits above the row field do not affect the row. PCs that are equal modulo `ROWS` instruction slots share a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_idx | output | ROW_W+HIST_W | Table index behind the prediction, {row, column} |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_idx | input | ROW_W+HIST_W | Index saved at prediction time |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
The assertions assume that `rst` is held high through the first clock edge. They also assume that `upd_idx` and `upd_taken` are known, never X, whenever `upd_valid` is high. The counter checks read the written cell one cycle later, so they rely on each update being a single-cycle pulse whose index is valid in that cycle. The bench drives every input at the falling edge, with reset asserted from time zero, and raises `upd_valid` only together with a defined index and outcome. It also chooses indices whose column matches the history it has built up, so that a later lookup lands on the cell just trained.

// File: rtl/bp_corr_pkg.sv
package bp_corr_pkg;

    // 2-bit saturating direction counter
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_INIT = CTR_WNT;

    // resolved-branch report carried into the history and table
    typedef struct packed {
        logic valid;
        logic taken;
    } outcome_t;

    function automatic ctr_e ctr_step(input ctr_e c, input logic taken);
        ctr_e n;
        case (c)
            CTR_SNT: n = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: n = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  n = taken ? CTR_ST  : CTR_WNT;
            default: n = taken ? CTR_ST  : CTR_WT;
        endcase
        return n;
    endfunction

    function automatic logic ctr_taken(input ctr_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/bp_index_gen.sv
module bp_index_gen #(
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2,
    parameter int ROW_W      = 4,
    parameter int HIST_W     = 2,
    localparam int IDX_W     = ROW_W + HIST_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    logic [ROW_W-1:0] row;

    assign row = pc[ALIGN_BITS +: ROW_W];
    assign idx = {row, hist};

    // bits outside the row field deliberately play no part
    logic unused_pc_bits;
    generate
        if (ALIGN_BITS + ROW_W < PC_W) begin : g_hi
            assign unused_pc_bits = ^{pc[PC_W-1:ALIGN_BITS+ROW_W], pc[ALIGN_BITS-1:0]};
        end else begin : g_nohi
            assign unused_pc_bits = ^pc[ALIGN_BITS-1:0];
        end
    endgenerate

endmodule

// File: rtl/bp_ghist.sv
module bp_ghist
    import bp_corr_pkg::*;
#(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  outcome_t          res,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_d;

    generate
        if (HIST_W == 1) begin : g_one
            assign hist_d = res.taken;
        end else begin : g_many
            assign hist_d = {hist[HIST_W-2:0], res.taken};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
        end else if (res.valid) begin
            hist <= hist_d;
        end
    end

    // R2: the newest outcome lands in bit 0 after a valid report
    p_newest_bit_r2: assert property (@(posedge clk) disable iff (rst)
        res.valid |=> hist[0] == $past(res.taken));

    // R2: the history is left alone without a valid report
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !res.valid |=> $stable(hist));

endmodule

// File: rtl/bp_pattern_table.sv
module bp_pattern_table
    import bp_corr_pkg::*;
#(
    parameter int IDX_W  = 6,
    localparam int CELLS = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_e             rd_ctr,
    input  outcome_t         res,
    input  logic [IDX_W-1:0] wr_idx
);
    ctr_e tbl [CELLS];
    ctr_e wr_old;

    assign rd_ctr = tbl[rd_idx];
    assign wr_old = tbl[wr_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CELLS; i++) begin
                tbl[i] <= CTR_INIT;
            end
        end else if (res.valid) begin
            tbl[wr_idx] <= ctr_step(wr_old, res.taken);
        end
    end

    // R5: taken moves a non-saturated counter up by one
    p_inc_r5: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.taken && wr_old != CTR_ST)
        |=> 2'(tbl[$past(wr_idx)]) == 2'(2'($past(wr_old)) + 2'd1));

    // R5: strong taken saturates
    p_sat_top_r5: assert property (@(posedge clk) disable iff (rst)
        (res.valid && res.taken && wr_old == CTR_ST)
        |=> tbl[$past(wr_idx)] == CTR_ST);

    // R6: not-taken moves a non-saturated counter down by one
    p_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (res.valid && !res.taken && wr_old != CTR_SNT)
        |=> 2'(tbl[$past(wr_idx)]) == 2'(2'($past(wr_old)) - 2'd1));

    // R6: strong not-taken saturates
    p_sat_bot_r6: assert property (@(posedge clk) disable iff (rst)
        (res.valid && !res.taken && wr_old == CTR_SNT)
        |=> tbl[$past(wr_idx)] == CTR_SNT);

    // R7: with no report the looked-up counter does not move
    p_idle_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !res.valid |=> tbl[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/corr_branch_predictor.sv
module corr_branch_predictor
    import bp_corr_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int ALIGN_BITS = 2,
    parameter int ROWS       = 16,
    parameter int HIST_W     = 2,
    localparam int ROW_W     = $clog2(ROWS),
    localparam int IDX_W     = ROW_W + HIST_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  pred_pc,
    output logic             pred_taken,
    output logic [IDX_W-1:0] pred_idx,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);
    outcome_t          res;
    logic [HIST_W-1:0] hist;
    ctr_e              sel_ctr;

    assign res.valid = upd_valid;
    assign res.taken = upd_taken;

    bp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk  (clk),
        .rst  (rst),
        .res  (res),
        .hist (hist)
    );

    bp_index_gen #(
        .PC_W       (PC_W),
        .ALIGN_BITS (ALIGN_BITS),
        .ROW_W      (ROW_W),
        .HIST_W     (HIST_W)
    ) u_idx (
        .pc   (pred_pc),
        .hist (hist),
        .idx  (pred_idx)
    );

    bp_pattern_table #(.IDX_W(IDX_W)) u_tbl (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (pred_idx),
        .rd_ctr (sel_ctr),
        .res    (res),
        .wr_idx (upd_idx)
    );

    assign pred_taken = ctr_taken(sel_ctr);

    // R1: the first lookup after reset is not taken
    p_reset_weak_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pred_taken);

    // R1: the first lookup after reset sees a zero history column
    p_reset_col_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pred_idx[HIST_W-1:0] == '0);

endmodule

// File: tb/sim_corr_branch_predictor.sv
`timescale 1ns/1ps
module sim_corr_branch_predictor;
    localparam int IDXW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [31:0]     pred_pc = '0;
    logic            pred_taken;
    logic [IDXW-1:0] pred_idx;
    logic            upd_valid = 1'b0;
    logic [IDXW-1:0] upd_idx = '0;
    logic            upd_taken = 1'b0;

    int checks = 0;
    int errors = 0;

    // reference state, built from the requirements alone
    logic [1:0] mctr [64];
    logic [1:0] mhist;

    always #2 clk = ~clk;

    corr_branch_predictor u0 (
        .clk(clk), .rst(rst), .pred_pc(pred_pc), .pred_taken(pred_taken),
        .pred_idx(pred_idx), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_taken(upd_taken)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_upd(input logic [5:0] idx, input logic tk);
        if (tk && mctr[idx] != 2'b11) mctr[idx] = mctr[idx] + 2'd1;
        else if (!tk && mctr[idx] != 2'b00) mctr[idx] = mctr[idx] - 2'd1;
        mhist = {mhist[0], tk};
    endtask

    task automatic do_upd(input logic [5:0] idx, input logic tk);
        @(negedge clk);
        upd_valid = 1'b1; upd_idx = idx; upd_taken = tk;
        @(negedge clk);
        upd_valid = 1'b0; upd_taken = 1'b0;
        model_upd(idx, tk);
    endtask

    task automatic look(input string req, input logic [31:0] pc);
        logic [5:0] e;
        pred_pc = pc;
        #1;
        e = {pc[5:2], mhist};
        chk(req, 32'(pred_idx), 32'(e));
        chk(req, 32'(pred_taken), 32'(mctr[e][1]));
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) look("R1", 32'h100 + 32'(i * 20));
    endtask

    task automatic t_index;
        pred_pc = 32'h0000_0024; #1;
        chk("R3", 32'(pred_idx), 32'(6'b1001_00));
        pred_pc = 32'h0000_0027; #1;
        chk("R9", 32'(pred_idx), 32'(6'b1001_00));
        pred_pc = 32'hABCD_0064; #1;
        chk("R9", 32'(pred_idx), 32'(6'b1001_00));
    endtask

    task automatic t_history;
        do_upd(6'h3F, 1'b1); look("R2", 32'h8);
        do_upd(6'h3E, 1'b0); look("R2", 32'h8);
        do_upd(6'h3D, 1'b1); look("R2", 32'h8);
        @(negedge clk);
        upd_taken = 1'b1;
        @(negedge clk);
        upd_taken = 1'b0;
        look("R2", 32'h8);
    endtask

    task automatic t_saturate;
        // cell {row5, col 11}: train up past the top
        for (int i = 0; i < 4; i++) do_upd({4'd5, 2'b11}, 1'b1);
        look("R5", 32'h14);
        do_upd({4'd5, 2'b11}, 1'b0);
        do_upd({4'd6, 2'b00}, 1'b1);
        do_upd({4'd6, 2'b00}, 1'b1);
        look("R5", 32'h14);
        look("R7", 32'h18);
        // drive it down past the bottom then back up twice
        for (int i = 0; i < 4; i++) do_upd({4'd5, 2'b11}, 1'b0);
        do_upd({4'd5, 2'b11}, 1'b1);
        do_upd({4'd5, 2'b11}, 1'b1);
        look("R6", 32'h14);
        look("R4", 32'h14);
    endtask

    task automatic t_same_cycle;
        logic [5:0] e;
        e = {4'd7, mhist};
        @(negedge clk);
        pred_pc = 32'h1C;
        upd_valid = 1'b1; upd_idx = e; upd_taken = 1'b1;
        #1;
        chk("R8", 32'(pred_idx), 32'(e));
        chk("R8", 32'(pred_taken), 32'(mctr[e][1]));
        @(negedge clk);
        upd_valid = 1'b0; upd_taken = 1'b0;
        model_upd(e, 1'b1);
        look("R8", 32'h1C);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mctr[i] = 2'b01;
        mhist = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_index();
        t_history();
        t_saturate();
        t_same_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule